// File: doc/BRIEF.md
# Granule-Striped Request Router

This block takes a stream of memory requests from one upstream valid/ready channel and steers each one to one of three downstream channels. Two of the downstream ports form an interleaved pair. Inside a configurable address window, one address bit chooses between them. That bit is the one whose weight equals the granule size, so with the default 4 KiB granule the pair alternates on every 4 KiB boundary. Any address outside the window goes to the fallback port. The address and the read/write flag pass through unchanged to every port, and the valid signal is raised only on the chosen port.

A 16-bit enable vector gates the router as a whole. Routing is allowed while any enable bit is high. A small controller state machine tracks the gate with a one-clock delay and has three states:

- `ST_OFF`: routing is gated off.
- `ST_IDLE`: routing is active and no request is stalled.
- `ST_HOLD`: a presented request was not accepted, and its port choice is frozen.

Its transitions are:

- `OFF->IDLE`: some enable bit is sampled high.
- `IDLE->HOLD`: a request is presented and its selected port is not ready.
- `IDLE->OFF`: every enable bit is sampled low and no request is stalled.
- `HOLD->IDLE`: the handshake completes, or valid drops, while enabled.
- `HOLD->OFF`: the same as HOLD->IDLE, but with every enable bit low.

Synchronous reset puts the controller in `ST_OFF`.

Top module: `stripe_router`

## Requirements
- R1: After reset, with no enable bit yet sampled high, `up_ready` is 0 and `dn_valid` is 3'b000.
- R2: Routing becomes active on the clock edge that samples any enable bit high. This holds for bit 0 alone and for bit 15 alone, and no request is routed in the cycle before that edge.
- R3: While routing is inactive (state `ST_OFF`), `up_ready` stays 0 and `dn_valid` stays 3'b000 even when `up_valid` is 1.
- R4: An address inside the window (WIN_BASE <= addr <= WIN_LIMIT, both bounds inclusive) with address bit log2(GRANULE) equal to 0 goes to port 1 (`dn_valid` = 3'b010).
- R5: An address inside the window with address bit log2(GRANULE) equal to 1 goes to port 2 (`dn_valid` = 3'b100).
- R6: An address below WIN_BASE or above WIN_LIMIT goes to port 0 (`dn_valid` = 3'b001).
- R7: The selected port's address slice `dn_addr[p*ADDR_W +: ADDR_W]` equals `up_addr` unchanged.
- R8: Both reads (`up_write` = 0) and writes (`up_write` = 1) are routed on every port, and `dn_write[p]` equals `up_write`.
- R9: `up_ready` equals the `dn_ready` bit of the selected port. The ready bits of the other ports have no effect.
- R10: At most one `dn_valid` bit is high at any time, and a bit is high only while `up_valid` is 1.
- R11: Once a request stalls, its selected port stays fixed until the handshake completes, even if the enable vector drops to all zeros meanwhile. The router then goes inactive on the edge that completes that handshake.
- R12: Reset is synchronous and active low. Asserting it while routing is active makes the router inactive at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | EN_W (16) | Enable vector; any high bit allows routing |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request accepted when high with up_valid |
| up_addr | input | ADDR_W (32) | Request address |
| up_write | input | 1 | 1 = write, 0 = read |
| dn_valid | output | 3 | Per-port request valid; bit p for port p |
| dn_ready | input | 3 | Per-port ready; bit p for port p |
| dn_addr | output | 3*ADDR_W | Per-port address; slice p is `[p*ADDR_W +: ADDR_W]` |
| dn_write | output | 3 | Per-port write flag |

## Verification
Some properties are checked by assertions on every clock cycle:

- at most one port is driven at a time, and only while `up_valid` is high;
- `up_ready` tracks the ready bit of whichever port is driven;
- the inactive state is quiet;
- a stalled request keeps its port on the following cycle;
- reset leaves the controller inactive.

Other behaviour can only be shown by the directed scenarios:

- the mapping from address to port, including both window bounds and the stripe bit;
- unmodified pass-through of the address and the write flag;
- the one-cycle latency of the enable gate;
- the sequence in which a stall survives the enable dropping and the router then turns off.

// File: rtl/stripe_router_pkg.sv
package stripe_router_pkg;

    localparam int NPORT = 3;

    typedef logic [1:0] port_idx_t;

    localparam port_idx_t PORT_FALLBACK = 2'd0;
    localparam port_idx_t PORT_EVEN     = 2'd1;
    localparam port_idx_t PORT_ODD      = 2'd2;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_HOLD = 2'd2
    } rt_state_e;

endpackage

// File: rtl/stripe_router_decode.sv
module stripe_router_decode
    import stripe_router_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter longint unsigned GRANULE   = 4096,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h0001_0000,
    parameter logic [ADDR_W-1:0] WIN_LIMIT = 32'h0004_FFFF
) (
    input  logic [ADDR_W-1:0] addr,
    output port_idx_t         port
);
    localparam int STRIPE_BIT = $clog2(GRANULE);

    logic in_window;
    logic stripe;

    always_comb begin
        in_window = (addr >= WIN_BASE) && (addr <= WIN_LIMIT);
        stripe    = addr[STRIPE_BIT];
        if (!in_window) begin
            port = PORT_FALLBACK;
        end else if (stripe) begin
            port = PORT_ODD;
        end else begin
            port = PORT_EVEN;
        end
    end
endmodule

// File: rtl/stripe_router_ctrl.sv
module stripe_router_ctrl
    import stripe_router_pkg::*;
#(
    parameter int EN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EN_W-1:0]  en,
    input  logic             up_valid,
    input  port_idx_t        dec_port,
    input  logic [NPORT-1:0] dn_ready,
    output port_idx_t        cur_port,
    output logic             route,
    output logic             up_ready,
    output logic             rt_off
);
    rt_state_e state_q, state_d;
    port_idx_t held_q, held_d;
    logic      en_any;
    logic      sel_ready;

    assign en_any = |en;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            held_q  <= PORT_FALLBACK;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
        end
    end

    // outputs
    always_comb begin
        cur_port = dec_port;
        route    = 1'b0;
        rt_off   = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                rt_off = 1'b1;
            end
            ST_IDLE: begin
                route = up_valid;
            end
            ST_HOLD: begin
                cur_port = held_q;
                route    = up_valid;
            end
            default: begin
                rt_off = 1'b1;
            end
        endcase
        unique case (cur_port)
            PORT_FALLBACK: sel_ready = dn_ready[0];
            PORT_EVEN:     sel_ready = dn_ready[1];
            PORT_ODD:      sel_ready = dn_ready[2];
            default:       sel_ready = 1'b0;
        endcase
        up_ready = route && sel_ready;
    end

    // next state
    always_comb begin
        state_d = state_q;
        held_d  = held_q;
        unique case (state_q)
            ST_OFF: begin
                if (en_any) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (up_valid && !up_ready) begin
                    state_d = ST_HOLD;
                    held_d  = dec_port;
                end else if (!en_any) begin
                    state_d = ST_OFF;
                end
            end
            ST_HOLD: begin
                if (!up_valid || up_ready) begin
                    state_d = en_any ? ST_IDLE : ST_OFF;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // R12: synchronous reset always lands in the inactive state
    a_r12_reset_off: assert property (@(posedge clk) !rst_n |=> rt_off);

    // R11: a stalled request stays in HOLD until it completes
    a_r11_hold_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && up_valid && !up_ready) |=> state_q == ST_HOLD);
endmodule

// File: rtl/stripe_router_fanout.sv
module stripe_router_fanout
    import stripe_router_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    route,
    input  port_idx_t               cur_port,
    input  logic [ADDR_W-1:0]       up_addr,
    input  logic                    up_write,
    output logic [NPORT-1:0]        dn_valid,
    output logic [NPORT*ADDR_W-1:0] dn_addr,
    output logic [NPORT-1:0]        dn_write
);
    for (genvar g = 0; g < NPORT; g++) begin : g_port
        assign dn_valid[g]                  = route && (cur_port == port_idx_t'(g));
        assign dn_addr[g*ADDR_W +: ADDR_W]  = up_addr;
        assign dn_write[g]                  = up_write;
    end

    // R10: never more than one port driven
    a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dn_valid));
endmodule

// File: rtl/stripe_router.sv
module stripe_router
    import stripe_router_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                EN_W      = 16,
    parameter longint unsigned   GRANULE   = 4096,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h0001_0000,
    parameter logic [ADDR_W-1:0] WIN_LIMIT = 32'h0004_FFFF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [EN_W-1:0]         en,
    input  logic                    up_valid,
    output logic                    up_ready,
    input  logic [ADDR_W-1:0]       up_addr,
    input  logic                    up_write,
    output logic [NPORT-1:0]        dn_valid,
    input  logic [NPORT-1:0]        dn_ready,
    output logic [NPORT*ADDR_W-1:0] dn_addr,
    output logic [NPORT-1:0]        dn_write
);
    port_idx_t dec_port;
    port_idx_t cur_port;
    logic      route;
    logic      rt_off;

    stripe_router_decode #(
        .ADDR_W    (ADDR_W),
        .GRANULE   (GRANULE),
        .WIN_BASE  (WIN_BASE),
        .WIN_LIMIT (WIN_LIMIT)
    ) u_decode (
        .addr (up_addr),
        .port (dec_port)
    );

    stripe_router_ctrl #(
        .EN_W (EN_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .up_valid (up_valid),
        .dec_port (dec_port),
        .dn_ready (dn_ready),
        .cur_port (cur_port),
        .route    (route),
        .up_ready (up_ready),
        .rt_off   (rt_off)
    );

    stripe_router_fanout #(
        .ADDR_W (ADDR_W)
    ) u_fanout (
        .clk      (clk),
        .rst_n    (rst_n),
        .route    (route),
        .cur_port (cur_port),
        .up_addr  (up_addr),
        .up_write (up_write),
        .dn_valid (dn_valid),
        .dn_addr  (dn_addr),
        .dn_write (dn_write)
    );

    // R3: inactive router is quiet on both sides
    a_r3_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rt_off |-> (dn_valid == '0 && !up_ready));

    // R10: a port is driven only while a request is offered
    a_r10_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (|dn_valid) |-> up_valid);

    // R11: a stalled request keeps its port on the next cycle
    a_r11_port_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_ready && (|dn_valid)) |=> (!up_valid || dn_valid == $past(dn_valid)));

    // R9: upstream ready follows the driven port's ready
    for (genvar p = 0; p < NPORT; p++) begin : g_rdy_chk
        a_r9_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
            dn_valid[p] |-> (up_ready == dn_ready[p]));
    end
endmodule

// File: tb/stripe_router_bench.sv
`timescale 1ns/1ps
module stripe_router_bench;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   en = '0;
    logic          up_valid = 1'b0;
    logic          up_ready;
    logic [AW-1:0] up_addr = '0;
    logic          up_write = 1'b0;
    logic [2:0]    dn_valid;
    logic [2:0]    dn_ready = 3'b111;
    logic [3*AW-1:0] dn_addr;
    logic [2:0]    dn_write;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    stripe_router u_stripe_router (
        .clk (clk), .rst_n (rst_n), .en (en),
        .up_valid (up_valid), .up_ready (up_ready),
        .up_addr (up_addr), .up_write (up_write),
        .dn_valid (dn_valid), .dn_ready (dn_ready),
        .dn_addr (dn_addr), .dn_write (dn_write)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // route one request to a ready port and check it (R4..R8)
    task automatic send(input string tag, input logic [31:0] a, input logic w, input int port);
        @(negedge clk);
        up_valid = 1'b1; up_addr = a; up_write = w; dn_ready = 3'b111;
        #1;
        chk({tag, " valid"}, 64'(dn_valid), 64'(3'b001 << port));
        chk({tag, " R7 addr"}, 64'(dn_addr[port*AW +: AW]), 64'(a));
        chk({tag, " R8 write"}, 64'(dn_write[port]), 64'(w));
        chk({tag, " R9 ready"}, 64'(up_ready), 64'd1);
        @(posedge clk);
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        up_valid = 1'b1; up_addr = 32'h0001_0000;
        #1;
        chk("R1 reset dn_valid", 64'(dn_valid), 64'd0);
        chk("R1 reset up_ready", 64'(up_ready), 64'd0);
        up_valid = 1'b0;
    endtask

    task automatic t_disabled;
        @(negedge clk);
        en = '0; up_valid = 1'b1; up_addr = 32'h0001_1000; dn_ready = 3'b111;
        for (int i = 0; i < 3; i++) begin
            #1;
            chk("R3 off dn_valid", 64'(dn_valid), 64'd0);
            chk("R3 off up_ready", 64'(up_ready), 64'd0);
            @(negedge clk);
        end
        up_valid = 1'b0;
    endtask

    task automatic t_enable(input logic [15:0] bits);
        @(negedge clk);
        en = bits; up_valid = 1'b1; up_addr = 32'h0001_0000; dn_ready = 3'b111;
        #1;
        chk("R2 before edge", 64'(dn_valid), 64'd0);
        @(negedge clk);
        #1;
        chk("R2 after edge", 64'(dn_valid), 64'(3'b010));
        up_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_turn_off;
        @(negedge clk);
        en = '0; up_valid = 1'b0;
        @(negedge clk);
        up_valid = 1'b1; up_addr = 32'h0000_0100;
        #1;
        chk("R3 after disable", 64'(dn_valid), 64'd0);
        up_valid = 1'b0;
    endtask

    task automatic t_ready_select;
        @(negedge clk);
        up_valid = 1'b1; up_addr = 32'h0002_2000; dn_ready = 3'b101;
        #1;
        chk("R9 other ports ready", 64'(up_ready), 64'd0);
        chk("R9 port1 driven", 64'(dn_valid), 64'(3'b010));
        dn_ready = 3'b010;
        #1;
        chk("R9 own ready", 64'(up_ready), 64'd1);
        @(posedge clk);
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic t_stall_hold;
        @(negedge clk);
        en = 16'h0040; up_valid = 1'b1; up_addr = 32'h0003_3000; dn_ready = 3'b000;
        #1;
        chk("R11 stall port2", 64'(dn_valid), 64'(3'b100));
        @(negedge clk);
        en = '0;
        #1;
        chk("R11 held with enable low", 64'(dn_valid), 64'(3'b100));
        @(negedge clk);
        #1;
        chk("R11 still held", 64'(dn_valid), 64'(3'b100));
        chk("R11 still stalled", 64'(up_ready), 64'd0);
        dn_ready = 3'b100;
        #1;
        chk("R11 complete ready", 64'(up_ready), 64'd1);
        @(negedge clk);
        up_addr = 32'h0003_2000; dn_ready = 3'b111;
        #1;
        chk("R11 off after handshake", 64'(dn_valid), 64'd0);
        up_valid = 1'b0;
    endtask

    task automatic t_sync_reset;
        @(negedge clk);
        en = 16'h0100; up_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        up_valid = 1'b1; up_addr = 32'h0001_0000;
        #1;
        chk("R12 sync before edge", 64'(dn_valid), 64'(3'b010));
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R12 after reset edge", 64'(dn_valid), 64'd0);
        @(negedge clk);
        #1;
        chk("R12 active again", 64'(dn_valid), 64'(3'b010));
        up_valid = 1'b0;
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_enable(16'h8000);
        t_turn_off();
        t_enable(16'h0001);
        send("R4 base", 32'h0001_0000, 1'b0, 1);
        send("R4 in stripe0", 32'h0001_0FFC, 1'b1, 1);
        send("R5 stripe1", 32'h0001_1000, 1'b0, 2);
        send("R5 limit", 32'h0004_FFFF, 1'b1, 2);
        send("R6 below base", 32'h0000_FFFF, 1'b0, 0);
        send("R6 above limit", 32'h0005_0000, 1'b1, 0);
        send("R6 high", 32'hFFFF_F000, 1'b0, 0);
        send("R8 read port2", 32'h0002_3004, 1'b0, 2);
        send("R8 write port0", 32'h0000_0000, 1'b1, 0);
        t_ready_select();
        t_stall_hold();
        t_sync_reset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule